// File: doc/BRIEF.md
# Pseudo-SRAM Power State Sequencer

This synchronous controller sits between a pseudo-SRAM device and the logic that runs its bus cycles. It moves the memory through five power states: a wait after supply power-up, active, standby, deep power-down, and a recovery wait after deep power-down. It drives two pins. The first is an active-low sleep control that puts the device into deep power-down. The second forces the chip enable inactive. It also gives the access controller a flag that says when bus cycles may run.

Both recovery waits are counted in clock cycles. The count comes from the clock period and the required wait in nanoseconds, rounded up. A request to go to deep power-down is taken only when the access controller reports idle, and only from standby. Because of this, the chip enable is already forced high for at least one cycle before the sleep pin falls.

The block also tracks whether the memory contents can still be trusted. The contents are lost on deep power-down and on loss of supply. They count as valid again once the host reports that the memory has been reinitialised.

Top module: `psram_pwr_seq`

## Requirements
- R1: Reset state: sleep_n_o=1, cs_block_o=1, access_ok_o=0 and data_valid_o=0. With pwr_good_i held at 1, access_ok_o rises exactly RECOVER_CYC clock edges after reset is released. RECOVER_CYC = ceil(RECOVER_NS*1000/CLK_PERIOD_PS), which is 26 for 203 ns at 8000 ps.
- R2: If pwr_good_i is sampled at 0, then after that edge access_ok_o=0, cs_block_o=1, sleep_n_o=1 and data_valid_o=0. The recovery count then restarts, so access_ok_o rises RECOVER_CYC edges after the last edge at which pwr_good_i was 0.
- R3: Active state (access_ok_o=1, cs_block_o=0) moves to standby (access_ok_o=1, cs_block_o=1) one edge after bus_idle_i=1 is sampled with wake_req_i=0. Standby returns to active one edge after wake_req_i=1 is sampled, with no recovery wait.
- R4: deep_req_i takes effect only in standby with bus_idle_i=1; sleep_n_o then falls at the next edge. In active with bus_idle_i=0, and in standby with bus_idle_i=0, deep_req_i has no effect.
- R5: cs_block_o is 1 in every cycle in which sleep_n_o=0. It is also 1 in the cycle before sleep_n_o falls and in the cycle after sleep_n_o rises.
- R6: sleep_n_o stays 0 for at least ZZ_MIN_CYC cycles, and for as long as deep_req_i stays 1. ZZ_MIN_CYC = ceil(ZZ_MIN_NS*1000/CLK_PERIOD_PS), with a minimum of 1; it is 4 for 30 ns at 8000 ps. sleep_n_o rises at the first edge at which the minimum has elapsed and deep_req_i=0.
- R7: After sleep_n_o rises, access_ok_o stays 0 and cs_block_o stays 1 for RECOVER_CYC cycles. The block then enters standby.
- R8: access_ok_o is 1 only in active and standby. It is never 1 while sleep_n_o=0 or during either recovery wait.
- R9: A wake_req_i=1 sampled in any cycle of the power-up wait, deep power-down or the exit wait is held. When the wait ends, the block goes straight to active (cs_block_o=0) instead of standby.
- R10: data_valid_o falls at the same edge at which sleep_n_o falls, and on loss of power. It becomes 1 one edge after init_done_i=1 is sampled in active. init_done_i has no effect in standby or during any wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply is within range |
| deep_req_i | input | 1 | Request for deep power-down (level) |
| wake_req_i | input | 1 | Request to go to, or stay in, active |
| bus_idle_i | input | 1 | Access controller has no bus cycle in flight |
| init_done_i | input | 1 | Host has rewritten or reinitialised the contents |
| sleep_n_o | output | 1 | To the device low-power pin; 0 = deep power-down |
| cs_block_o | output | 1 | 1 = force the device chip enable inactive |
| access_ok_o | output | 1 | Bus cycles are allowed |
| data_valid_o | output | 1 | Memory contents are valid |

## Verification
The assertions take for granted that bus_idle_i is truthful. The access controller must start no bus cycle while access_ok_o is 0, and must keep bus_idle_i at 0 while a cycle is in flight. The assertions also assume that pwr_good_i is already synchronous to clk_i. The stimulus drives all inputs one step after the rising edge. It raises deep_req_i only together with bus_idle_i, or to show that the request is ignored. It pulses wake_req_i and pwr_good_i only at points where the expected state is known from the requirements.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [2:0] {
    PS_PWRUP     = 3'd0,
    PS_ACTIVE    = 3'd1,
    PS_STANDBY   = 3'd2,
    PS_DEEP      = 3'd3,
    PS_DEEP_EXIT = 3'd4
  } pwr_state_e;

  // ceil(ns * 1000 / period_ps), never below one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ps);
    longint unsigned ps_total;
    longint unsigned cyc;
    ps_total = 64'(ns) * 64'd1000;
    cyc      = (ps_total + 64'(period_ps) - 64'd1) / 64'(period_ps);
    if (cyc == 64'd0) cyc = 64'd1;
    return 32'(cyc);
  endfunction

endpackage

// File: rtl/pwr_wait_timer.sv
module pwr_wait_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (en_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_pin_drive.sv
module pwr_pin_drive
  import psram_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pwr_state_e state_d_i,
  output logic       sleep_n_o,
  output logic       cs_block_o,
  output logic       access_ok_o
);
  logic sleep_n_d, cs_block_d, access_ok_d;

  always_comb begin
    sleep_n_d   = 1'b1;
    cs_block_d  = 1'b1;
    access_ok_d = 1'b0;
    unique case (state_d_i)
      PS_ACTIVE: begin
        cs_block_d  = 1'b0;
        access_ok_d = 1'b1;
      end
      PS_STANDBY:   access_ok_d = 1'b1;
      PS_DEEP:      sleep_n_d   = 1'b0;
      PS_PWRUP,
      PS_DEEP_EXIT: access_ok_d = 1'b0;
      default:      access_ok_d = 1'b0;
    endcase
  end

  // flops on the pins: no decode glitches reach the device
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_n_o   <= 1'b1;
      cs_block_o  <= 1'b1;
      access_ok_o <= 1'b0;
    end else begin
      sleep_n_o   <= sleep_n_d;
      cs_block_o  <= cs_block_d;
      access_ok_o <= access_ok_d;
    end
  end
endmodule

// File: rtl/pwr_valid_track.sv
module pwr_valid_track
  import psram_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pwr_state_e state_q_i,
  input  pwr_state_e state_d_i,
  input  logic       init_done_i,
  output logic       valid_o
);
  logic lose, regain;

  assign lose   = (state_d_i == PS_DEEP) || (state_d_i == PS_PWRUP);
  assign regain = init_done_i && (state_q_i == PS_ACTIVE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     valid_o <= 1'b0;
    else if (lose)   valid_o <= 1'b0;
    else if (regain) valid_o <= 1'b1;
  end
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned RECOVER_NS    = 300000,
  parameter int unsigned ZZ_MIN_NS     = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic deep_req_i,
  input  logic wake_req_i,
  input  logic bus_idle_i,
  input  logic init_done_i,
  output logic sleep_n_o,
  output logic cs_block_o,
  output logic access_ok_o,
  output logic data_valid_o
);
  localparam int unsigned RECOVER_CYC = ns_to_cycles(RECOVER_NS, CLK_PERIOD_PS);
  localparam int unsigned ZZ_MIN_CYC  = ns_to_cycles(ZZ_MIN_NS, CLK_PERIOD_PS);
  localparam int unsigned N_TMR       = 2;
  localparam int unsigned T_REC       = 0;
  localparam int unsigned T_LOW       = 1;

  pwr_state_e state_q, state_d;
  logic       wake_pend_q, wake_pend_d;
  logic       waiting;
  logic [N_TMR-1:0] tmr_clr, tmr_en, tmr_done;

  assign waiting = (state_q == PS_PWRUP) || (state_q == PS_DEEP) ||
                   (state_q == PS_DEEP_EXIT);

  // recovery timer serves both the power-up and the exit wait
  assign tmr_en[T_REC]  = (state_q == PS_PWRUP) || (state_q == PS_DEEP_EXIT);
  assign tmr_clr[T_REC] = !tmr_en[T_REC] || (state_d != state_q) || !pwr_good_i;
  assign tmr_en[T_LOW]  = (state_q == PS_DEEP);
  assign tmr_clr[T_LOW] = !tmr_en[T_LOW] || (state_d != state_q);

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    pwr_wait_timer #(
      .LIMIT((g == T_REC) ? RECOVER_CYC : ZZ_MIN_CYC)
    ) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(tmr_clr[g]),
      .en_i   (tmr_en[g]),
      .done_o (tmr_done[g])
    );
  end

  always_comb begin
    state_d = state_q;
    if (!pwr_good_i) begin
      state_d = PS_PWRUP;
    end else begin
      unique case (state_q)
        PS_PWRUP, PS_DEEP_EXIT: begin
          if (tmr_done[T_REC])
            state_d = (wake_pend_q || wake_req_i) ? PS_ACTIVE : PS_STANDBY;
        end
        PS_ACTIVE: begin
          if (bus_idle_i && !wake_req_i) state_d = PS_STANDBY;
        end
        PS_STANDBY: begin
          // chip enable already forced here, so sleep pin falls with setup
          if (deep_req_i && bus_idle_i) state_d = PS_DEEP;
          else if (wake_req_i)          state_d = PS_ACTIVE;
        end
        PS_DEEP: begin
          if (tmr_done[T_LOW] && !deep_req_i) state_d = PS_DEEP_EXIT;
        end
        default: state_d = PS_PWRUP;
      endcase
    end
  end

  assign wake_pend_d = waiting ? (wake_pend_q || wake_req_i) : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PS_PWRUP;
      wake_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      wake_pend_q <= wake_pend_d;
    end
  end

  pwr_pin_drive u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_d_i  (state_d),
    .sleep_n_o  (sleep_n_o),
    .cs_block_o (cs_block_o),
    .access_ok_o(access_ok_o)
  );

  pwr_valid_track u_valid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_q_i  (state_q),
    .state_d_i  (state_d),
    .init_done_i(init_done_i),
    .valid_o    (data_valid_o)
  );
endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk
  import psram_pwr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned RECOVER_NS    = 300000,
  parameter int unsigned ZZ_MIN_NS     = 30
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_good_i,
  input logic deep_req_i,
  input logic bus_idle_i,
  input logic init_done_i,
  input logic sleep_n_o,
  input logic cs_block_o,
  input logic access_ok_o,
  input logic data_valid_o
);
  localparam int unsigned REC_CYC = ns_to_cycles(RECOVER_NS, CLK_PERIOD_PS);
  localparam int unsigned LOW_CYC = ns_to_cycles(ZZ_MIN_NS, CLK_PERIOD_PS);
  localparam int unsigned RW = $clog2(REC_CYC + 1);
  localparam int unsigned LW = $clog2(LOW_CYC + 1);
  localparam logic [RW-1:0] REC_SAT = RW'(REC_CYC);
  localparam logic [LW-1:0] LOW_SAT = LW'(LOW_CYC);

  logic [RW-1:0] quiet_cnt;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_cnt <= '0;
      low_cnt   <= '0;
    end else begin
      if (sleep_n_o && !access_ok_o && pwr_good_i) begin
        if (quiet_cnt != REC_SAT) quiet_cnt <= quiet_cnt + 1'b1;
      end else begin
        quiet_cnt <= '0;
      end
      if (!sleep_n_o) begin
        if (low_cnt != LOW_SAT) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
    end
  end

  // R1 and R7: access only after a full quiet window
  p_recover_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(access_ok_o) |-> quiet_cnt >= REC_SAT);

  p_power_loss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !access_ok_o && !data_valid_o && cs_block_o && sleep_n_o);

  p_deep_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_n_o) |-> $past(deep_req_i) && $past(bus_idle_i) &&
                         $past(access_ok_o) && $past(cs_block_o));

  p_cs_during_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_n_o |-> cs_block_o);

  p_cs_before_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_n_o) |-> $past(cs_block_o));

  p_cs_after_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_n_o) |=> cs_block_o);

  p_low_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_n_o) |-> low_cnt >= LOW_SAT);

  p_ok_awake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_ok_o |-> sleep_n_o);

  p_valid_lost_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_n_o) |-> !data_valid_o);

  p_valid_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_valid_o) |-> $past(init_done_i) && $past(access_ok_o) &&
                            !$past(cs_block_o));
endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .CLK_PERIOD_PS(CLK_PERIOD_PS),
  .RECOVER_NS   (RECOVER_NS),
  .ZZ_MIN_NS    (ZZ_MIN_NS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_good_i  (pwr_good_i),
  .deep_req_i  (deep_req_i),
  .bus_idle_i  (bus_idle_i),
  .init_done_i (init_done_i),
  .sleep_n_o   (sleep_n_o),
  .cs_block_o  (cs_block_o),
  .access_ok_o (access_ok_o),
  .data_valid_o(data_valid_o)
);

// File: tb/sim_psram_pwr_seq.sv
module sim_psram_pwr_seq;
  localparam int unsigned PERIOD_PS = 8000;
  localparam int unsigned REC_NS    = 203;
  localparam int unsigned LOW_NS    = 30;
  // R1 and R6 rounding, computed from the requirement text
  localparam int unsigned REC_CYC = (REC_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int unsigned LOW_CYC = (LOW_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b1, dr = 1'b0, wk = 1'b0, idl = 1'b1, ini = 1'b0;
  logic sleep_n, cs_block, ok, valid;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  psram_pwr_seq #(
    .CLK_PERIOD_PS(PERIOD_PS),
    .RECOVER_NS   (REC_NS),
    .ZZ_MIN_NS    (LOW_NS)
  ) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pwr_good_i  (pg),
    .deep_req_i  (dr),
    .wake_req_i  (wk),
    .bus_idle_i  (idl),
    .init_done_i (ini),
    .sleep_n_o   (sleep_n),
    .cs_block_o  (cs_block),
    .access_ok_o (ok),
    .data_valid_o(valid)
  );

  typedef struct packed {
    logic pg, dr, wk, idl, ini;
    logic e_sl, e_cs, e_ok, e_vl;
    logic [3:0] req;
  } vec_t;

  // starts in standby with contents invalid
  localparam vec_t VECS [13] = '{
    '{1,0,0,1,1, 1,1,1,0, 4'd10}, // R10 init in standby ignored
    '{1,1,0,0,0, 1,1,1,0, 4'd4},  // R4 deep req, bus busy, ignored
    '{1,0,1,1,0, 1,0,1,0, 4'd3},  // R3 wake -> active
    '{1,0,0,0,1, 1,0,1,1, 4'd10}, // R10 init in active sets valid
    '{1,1,0,0,0, 1,0,1,1, 4'd4},  // R4 deep req while active and busy
    '{1,0,0,1,0, 1,1,1,1, 4'd3},  // R3 idle -> standby
    '{1,0,1,0,0, 1,0,1,1, 4'd3},  // R3 wake -> active, no wait
    '{1,1,0,1,0, 1,1,1,1, 4'd4},  // R4 passes through standby first
    '{1,1,0,1,0, 0,1,0,0, 4'd10}, // R10 R5 R8 deep entry
    '{1,0,0,1,0, 0,1,0,0, 4'd6},  // R6 minimum width
    '{1,0,0,1,0, 0,1,0,0, 4'd6},
    '{1,0,0,1,0, 0,1,0,0, 4'd6},
    '{1,0,0,1,0, 1,1,0,0, 4'd5}   // R5 R6 rises after 4 low cycles, cs held
  };

  task automatic check(input string tag, input logic e_sl, e_cs, e_ok, e_vl);
    n_chk++;
    if ({sleep_n, cs_block, ok, valid} !== {e_sl, e_cs, e_ok, e_vl}) begin
      n_fail++;
      $display("FAIL %s: sleep_n/cs_block/access_ok/valid got %b%b%b%b expected %b%b%b%b",
               tag, sleep_n, cs_block, ok, valid, e_sl, e_cs, e_ok, e_vl);
    end
  endtask

  task automatic step(input logic p, d, w, i, n);
    pg = p; dr = d; wk = w; idl = i; ini = n;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_steps(input int unsigned n);
    for (int k = 0; k < int'(n); k++) step(1, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk++;
    if (REC_CYC != 26 || LOW_CYC != 4) begin
      n_fail++;
      $display("FAIL R1: rounding got %0d/%0d expected 26/4", REC_CYC, LOW_CYC);
    end
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 1, 1, 0, 0);
    rst_n = 1'b1;

    // R1 power-up wait
    idle_steps(REC_CYC - 1);
    check("R1 still waiting", 1, 1, 0, 0);
    step(1, 0, 0, 1, 0);
    check("R1 standby after wait", 1, 1, 1, 0);

    for (int v = 0; v < 13; v++) begin
      step(VECS[v].pg, VECS[v].dr, VECS[v].wk, VECS[v].idl, VECS[v].ini);
      check($sformatf("R%0d vec %0d", VECS[v].req, v),
            VECS[v].e_sl, VECS[v].e_cs, VECS[v].e_ok, VECS[v].e_vl);
    end

    // R7 exit wait ends in standby without wake
    idle_steps(REC_CYC - 1);
    check("R7 exit wait", 1, 1, 0, 0);
    step(1, 0, 0, 1, 0);
    check("R7 standby after exit", 1, 1, 1, 0);

    // R6 held low while requested; R9 wake during deep held
    step(1, 1, 0, 1, 0);
    check("R6 entry", 0, 1, 0, 0);
    for (int k = 0; k < 8; k++) step(1, 1, (k == 3), 1, 0);
    check("R6 request holds low", 0, 1, 0, 0);
    step(1, 0, 0, 1, 0);
    check("R6 release", 1, 1, 0, 0);
    idle_steps(REC_CYC - 1);
    check("R9 exit wait", 1, 1, 0, 0);
    step(1, 0, 1, 0, 0);
    check("R9 straight to active", 1, 0, 1, 0);

    step(1, 0, 1, 0, 1);
    check("R10 valid set", 1, 0, 1, 1);

    // R2 power loss and restart of the count
    step(0, 0, 0, 0, 0);
    check("R2 power loss", 1, 1, 0, 0);
    for (int k = 0; k < 10; k++) step(1, 0, 0, 1, (k == 2));
    check("R10 init in wait ignored", 1, 1, 0, 0);
    step(0, 0, 0, 1, 0);
    check("R2 drop mid-wait", 1, 1, 0, 0);
    step(1, 0, 1, 1, 0);
    idle_steps(REC_CYC - 2);
    check("R2 count restarted", 1, 1, 0, 0);
    step(1, 0, 0, 0, 0);
    check("R9 R2 active after power-up", 1, 0, 1, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule